// File: doc/BRIEF.md
# Event-Driven Integrate-and-Fire Neuron

This block is one digital spiking neuron for a self-timed layer of a spiking network. A set of input spike lines, one per presynaptic source, feeds a round-robin arbiter. Spikes that arrive together are parked in per-input pending bits and handed on one per clock cycle. The index of the granted input picks a signed 8-bit synaptic weight from a small register file. An integrate-and-fire unit adds that weight to a membrane accumulator.

The accumulator never drops below zero. A sum that would be negative is clamped to zero, which acts as a ReLU. When a sum carries past the accumulator width, the neuron emits a one-cycle output spike and keeps the wrapped remainder. When no input is pending, the datapath does no work and the membrane holds its value.

Weights are loaded through a plain write port. A sticky flag records that a spike was merged into one that was already waiting on the same input.

Top module: `spk_neuron`

## Requirements
- R1: While `wr_en` is high at a clock edge, `wr_data` is stored as an 8-bit two's-complement weight for input index `wr_addr`. A write to an index of `N_IN` or above changes no weight. That weight is used from the next grant on.
- R2: A spike on `spk_in[i]` sampled at one edge is granted at the earliest on the next edge. At the grant, weight i is added to the membrane, and the result shows on `mem_out` right after that grant edge.
- R3: When membrane plus weight is negative, the membrane becomes 0 (ReLU floor).
- R4: When membrane plus weight is 2^ACC_W or more, `fire_out` is high for exactly the cycle after that grant edge. The membrane keeps the sum minus 2^ACC_W. In every other cycle `fire_out` is low.
- R5: At most one pending input is granted per cycle, and one is always granted when any is pending. The search starts at the index just after the last granted one (index 0 after reset), goes upward and wraps from N_IN-1 to 0.
- R6: A spike on an input that is already pending and is not granted in that cycle is counted once. It also sets `lost_flag`, which stays high until reset.
- R7: In a cycle with nothing pending, the membrane keeps its value and `fire_out` stays low, whatever is written to the weights.
- R8: After reset, `mem_out`, `fire_out` and `lost_flag` are 0. All weights and pending bits are 0, and the round-robin search starts at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spk_in | input | N_IN | One spike line per input, each a one-cycle pulse |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | $clog2(N_IN) | Input index of the weight being written |
| wr_data | input | 8 | Signed weight value |
| fire_out | output | 1 | Output spike, one cycle wide |
| mem_out | output | ACC_W | Membrane accumulator value |
| lost_flag | output | 1 | Sticky flag for a spike merged into a pending one |

## Verification
The bench uses the defaults: 46 inputs and an 8-bit membrane. With 46 inputs, write indices 46 to 63 exist on the 6-bit address, so ignored writes can be driven. The search pointer also wraps from 45 to 0 when all inputs fire together. The 8-bit membrane overflows after a few large positive weights, so the fire pulse, the wrapped remainder and the ReLU floor all occur often under random spike masks and random signed weights.

// File: rtl/neu_pkg.sv
package neu_pkg;
  localparam int WEIGHT_W = 8;
  typedef logic signed [WEIGHT_W-1:0] weight_t;
endpackage

// File: rtl/nw_rr_arbiter.sv
module nw_rr_arbiter #(
  parameter int N_IN = 46,
  localparam int IW = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] spk_in,
  output logic [N_IN-1:0] pend,
  output logic [N_IN-1:0] grant,
  output logic [IW-1:0]   gnt_idx,
  output logic            gnt_vld,
  output logic            lost
);
  logic [IW-1:0] ptr;

  // priority search starting at ptr, wrapping at N_IN
  always_comb begin
    grant   = '0;
    gnt_idx = '0;
    gnt_vld = 1'b0;
    for (int k = 0; k < N_IN; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N_IN) j = j - N_IN;
      if (!gnt_vld && pend[j]) begin
        gnt_vld  = 1'b1;
        gnt_idx  = IW'(j);
        grant[j] = 1'b1;
      end
    end
  end

  logic [N_IN-1:0] merge_hit;
  assign merge_hit = spk_in & pend & ~grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      ptr  <= '0;
      lost <= 1'b0;
    end else begin
      pend <= (pend & ~grant) | spk_in;
      if (gnt_vld)
        ptr <= (int'(gnt_idx) == N_IN - 1) ? '0 : gnt_idx + 1'b1;
      if (|merge_hit)
        lost <= 1'b1;
    end
  end
endmodule

// File: rtl/nw_weights.sv
module nw_weights #(
  parameter int N_IN = 46,
  localparam int IW = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_addr,
  input  neu_pkg::weight_t wr_data,
  input  logic [IW-1:0]    rd_idx,
  output neu_pkg::weight_t rd_data
);
  neu_pkg::weight_t mem [N_IN];

  for (genvar g = 0; g < N_IN; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (wr_en && wr_addr == IW'(g))
        mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/nw_integrate.sv
module nw_integrate #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  neu_pkg::weight_t w,
  output logic [ACC_W-1:0] acc,
  output logic             fire
);
  localparam int SW = ACC_W + 2;

  function automatic logic signed [SW-1:0] add_w(input logic [ACC_W-1:0] a,
                                                 input neu_pkg::weight_t wt);
    logic signed [SW-1:0] ext;
    ext = {{(SW - neu_pkg::WEIGHT_W){wt[neu_pkg::WEIGHT_W-1]}}, wt};
    return $signed({2'b00, a}) + ext;
  endfunction

  logic signed [SW-1:0] sum;
  logic [ACC_W-1:0]     acc_nx;
  logic                 carry;

  always_comb begin
    sum    = add_w(acc, w);
    carry  = 1'b0;
    acc_nx = sum[ACC_W-1:0];
    if (sum[SW-1])
      acc_nx = '0;
    else if (sum[ACC_W])
      carry = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= en & carry;
      if (en) acc <= acc_nx;
    end
  end
endmodule

// File: rtl/spk_neuron.sv
module spk_neuron #(
  parameter int N_IN  = 46,
  parameter int ACC_W = 8,
  localparam int IW = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  spk_in,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  output logic             fire_out,
  output logic [ACC_W-1:0] mem_out,
  output logic             lost_flag
);
  logic [N_IN-1:0]  pend;
  logic [N_IN-1:0]  grant;
  logic [IW-1:0]    gnt_idx;
  logic             gnt_vld;
  neu_pkg::weight_t wsel;

  nw_rr_arbiter #(.N_IN(N_IN)) u_arb (
    .clk(clk), .rst_n(rst_n), .spk_in(spk_in), .pend(pend), .grant(grant),
    .gnt_idx(gnt_idx), .gnt_vld(gnt_vld), .lost(lost_flag)
  );

  nw_weights #(.N_IN(N_IN)) u_wts (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(neu_pkg::weight_t'(wr_data)), .rd_idx(gnt_idx), .rd_data(wsel)
  );

  nw_integrate #(.ACC_W(ACC_W)) u_if (
    .clk(clk), .rst_n(rst_n), .en(gnt_vld), .w(wsel), .acc(mem_out), .fire(fire_out)
  );
endmodule

// File: rtl/spk_neuron_chk.sv
module spk_neuron_chk #(
  parameter int N_IN  = 46,
  parameter int ACC_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_IN-1:0]     pend,
  input logic [N_IN-1:0]     grant,
  input logic                gnt_vld,
  input logic signed [7:0]   wsel,
  input logic [ACC_W-1:0]    mem_out,
  input logic                fire_out,
  input logic                lost_flag
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_GRANT_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0); // R5
  AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> gnt_vld); // R5
  AST_FIRE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    fire_out |-> ($past(gnt_vld) && $past(wsel) > 0)); // R4
  AST_RELU_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && wsel < 0) |=> (mem_out <= $past(mem_out) && !fire_out)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |=> ($stable(mem_out) && !fire_out)); // R7
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lost_flag |=> lost_flag); // R6
endmodule

bind spk_neuron spk_neuron_chk #(.N_IN(N_IN), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .grant(grant), .gnt_vld(gnt_vld),
  .wsel(wsel), .mem_out(mem_out), .fire_out(fire_out), .lost_flag(lost_flag)
);

// File: tb/sim_spk_neuron.sv
`timescale 1ns/1ps
module sim_spk_neuron;
  localparam int N   = 46;
  localparam int AW  = $clog2(N);
  localparam int ACW = 8;
  localparam int ACC_MAX = 1 << ACW;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] spk_in = '0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic fire_out;
  logic [ACW-1:0] mem_out;
  logic lost_flag;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [N-1:0] m_pend;
  int m_w [N];
  int m_acc, m_ptr;
  bit m_fire, m_lost;

  always #5 clk = ~clk;

  spk_neuron #(.N_IN(N), .ACC_W(ACW)) u0 (
    .clk(clk), .rst_n(rst_n), .spk_in(spk_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fire_out(fire_out), .mem_out(mem_out), .lost_flag(lost_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(int'(mem_out) == m_acc, {tag, " membrane"}, int'(mem_out), m_acc);
    check(fire_out == m_fire, "R4 fire pulse", int'(fire_out), int'(m_fire));
    check(lost_flag == m_lost, "R6 lost flag", int'(lost_flag), int'(m_lost));
  endtask

  function automatic void model_reset();
    m_pend = '0; m_acc = 0; m_ptr = 0; m_fire = 0; m_lost = 0;
    for (int i = 0; i < N; i++) m_w[i] = 0;
  endfunction

  function automatic int step_acc(input int a, input int w, output bit f);
    int s;
    s = a + w;
    f = 0;
    if (s < 0) return 0;
    if (s >= ACC_MAX) begin f = 1; return s - ACC_MAX; end
    return s;
  endfunction

  function automatic void model_edge(input logic [N-1:0] spk, input bit we,
                                     input int wa, input int wd);
    int g;
    bit f;
    g = -1;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (m_ptr + k) % N;
      if (g < 0 && m_pend[idx]) g = idx;
    end
    m_fire = 0;
    if (g >= 0) begin
      m_acc  = step_acc(m_acc, m_w[g], f);
      m_fire = f;
      m_ptr  = (g + 1) % N;
    end
    for (int i = 0; i < N; i++) begin
      if (spk[i] && m_pend[i] && i != g) m_lost = 1;
      m_pend[i] = (m_pend[i] && i != g) || spk[i];
    end
    if (we && wa < N) m_w[wa] = wd;
  endfunction

  task automatic step(input logic [N-1:0] spk, input bit we, input int wa,
                      input int wd, input string tag);
    @(negedge clk);
    compare(tag);
    spk_in  = spk;
    wr_en   = we;
    wr_addr = AW'(wa);
    wr_data = 8'(wd);
    model_edge(spk, we, wa, wd);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, 0, 0, 0, tag);
  endtask

  task automatic one(input int i, input string tag);
    logic [N-1:0] m;
    m = '0; m[i] = 1'b1;
    step(m, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset values
    idle(2, "R8");
    // R1: weight loading, including ignored high indices
    for (int i = 0; i < N; i++) begin
      int w;
      w = (i == 0) ? 100 : (i == 1) ? -50 : (i == 2) ? 127 : (i == 3) ? -128
        : ((i * 7) % 41) - 20;
      step('0, 1, i, w, "R1");
    end
    for (int a = N; a < (1 << AW); a++) step('0, 1, a, 99, "R1");
    idle(1, "R1");
    // R2: single spikes accumulate; R4: third spike of +100 overflows
    for (int r = 0; r < 3; r++) begin one(0, "R2"); idle(2, "R2"); end
    // R4: large weights, wrap remainder
    for (int r = 0; r < 4; r++) begin one(2, "R4"); idle(1, "R4"); end
    // R3: negative weights drive to floor
    for (int r = 0; r < 4; r++) begin one(3, "R3"); idle(1, "R3"); end
    one(1, "R3"); idle(2, "R3");
    // R7: idle with weight writes does nothing
    step('0, 1, 5, 77, "R7");
    idle(5, "R7");
    // R5: all inputs at once, served in rotating order with wrap
    one(10, "R5"); idle(2, "R5");
    step('1, 0, 0, 0, "R5");
    idle(N + 2, "R5");
    // R6: repeat while pending
    step('1, 0, 0, 0, "R6");
    step('1, 0, 0, 0, "R6");
    idle(N + 2, "R6");
    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] m;
      int dens;
      bit we;
      dens = $urandom_range(0, 3);
      m = '0;
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 99) < dens * 2) m[i] = 1'b1;
      we = ($urandom_range(0, 9) == 0);
      step(m, we, $urandom_range(0, (1 << AW) - 1), $urandom_range(0, 255) - 128, "R2");
    end
    idle(N + 2, "R7");
    @(negedge clk);
    compare("R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule